// File: doc/BRIEF.md
# Reference Clock Synchronizer State Machine

This block supervises the timing mode of a digital clock-recovery loop. It watches status inputs from the rest of the loop: a valid flag for each candidate reference, an activity flag for the currently selected reference, a phase-lock indication and a one-cycle timebase tick. From these it decides whether the loop runs free from the local oscillator, is qualifying a reference, is locked, or is holding its last good frequency. Six states cover this. Three are lasting modes: free-run, locked and holdover. Three are transient: prelocked, prelocked 2 and loss-of-lock.

Lock and inactivity qualification windows are counted in timebase ticks. With a 1 Hz tick, the default counts give a two-second window. Software can pin the machine to any state through a force request. Every state change, whether it comes from a force or from the automatic rules, sets a sticky status bit. Software clears that bit by writing one, and the bit drives an interrupt request when the interrupt is enabled. All inputs are plain level or pulse status. None of them is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `refsync_fsm`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the state is free-run (code 000), the sticky status bit is 0 and the interrupt request is 0.
- R2: In free-run with no force, the machine enters prelocked (100) on the next clock edge if any bit of `ref_valid` is 1. With all bits 0 it stays in free-run.
- R3: In prelocked, once `QUAL_TICKS` ticks have been counted with `phase_lock` high throughout, the machine enters locked (010) on the edge after the edge that registered the final tick. Any cycle with `phase_lock` low restarts the count from zero.
- R4: In prelocked, once `QUAL_TICKS` ticks have been counted with `sel_active` low throughout, the machine returns to free-run. If lock and inactivity both qualify in the same cycle, lock wins.
- R5: While `force_en` is high, the state on the next edge is the one decoded from `force_state`, whatever the automatic rules would choose.
- R6: Any edge that changes the state sets `stat_chg`. The bit then stays set until a cycle with `stat_clr` high and no state change. A state change in the same cycle as a clear leaves it set.
- R7: `irq` is high exactly when `stat_chg` and `irq_en` are both high.
- R8: In locked, a low `sel_active` moves the machine to holdover (001). Otherwise, a low `phase_lock` moves it to loss-of-lock (101).
- R9: In loss-of-lock, a low `sel_active` moves the machine to holdover. Otherwise, a high `phase_lock` returns it to locked. If neither happens within `LOL_TICKS` ticks, it moves to holdover on the edge after the final tick.
- R10: In holdover, any valid reference moves the machine to prelocked 2 (011). Prelocked 2 uses the same lock and inactivity qualification as prelocked, but it goes to locked on success and to holdover on inactivity.
- R11: State codes are 000 free-run, 001 holdover, 010 locked, 011 prelocked 2, 100 prelocked, 101 loss-of-lock. A forced code of 110 or 111 is taken as free-run, and the state output never shows those two codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | NUM_REFS | Per-reference valid flags |
| sel_active | input | 1 | Selected reference is active |
| phase_lock | input | 1 | Phase detector reports lock |
| tick | input | 1 | One-cycle timebase pulse |
| force_en | input | 1 | Software force request |
| force_state | input | 3 | Forced state code |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| state_code | output | 3 | Current state code |
| stat_chg | output | 1 | Sticky state-change status |
| irq | output | 1 | Interrupt request |

## Verification
The lock qualification is driven twice. In the first run, a dropout after three of four ticks must restart the count: the machine has to stay in prelocked after a fourth tick and lock only after a full uninterrupted window, which separates a restarting counter from one that only pauses. Loss-of-lock is tested with a quick lock recovery and with a full timeout, and holdover is re-entered both through inactivity in prelocked 2 and through the selected reference vanishing while locked. Forces are applied against inputs that would otherwise move the machine, including the unused codes. The status bit is cleared on a quiet cycle and again on a cycle that also changes state, which shows that set takes priority over clear.

// File: rtl/refsync_pkg.sv
package refsync_pkg;
  typedef enum logic [2:0] {
    ST_FREE = 3'b000,
    ST_HOLD = 3'b001,
    ST_LOCK = 3'b010,
    ST_PRE2 = 3'b011,
    ST_PRE  = 3'b100,
    ST_LOL  = 3'b101
  } sync_st_e;

  localparam int NUM_QUAL = 3;
  localparam int Q_LOCK   = 0;
  localparam int Q_INACT  = 1;
  localparam int Q_LOL    = 2;

  function automatic sync_st_e decode_code(input logic [2:0] c);
    case (c)
      3'b001:  return ST_HOLD;
      3'b010:  return ST_LOCK;
      3'b011:  return ST_PRE2;
      3'b100:  return ST_PRE;
      3'b101:  return ST_LOL;
      default: return ST_FREE;
    endcase
  endfunction
endpackage

// File: rtl/refsync_qual.sv
module refsync_qual #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!en)              cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == LIM);
endmodule

// File: rtl/refsync_next.sv
module refsync_next
  import refsync_pkg::*;
(
  input  sync_st_e    cur,
  input  logic        any_valid,
  input  logic        sel_active,
  input  logic        phase_lock,
  input  logic        lock_done,
  input  logic        inact_done,
  input  logic        lol_done,
  input  logic        force_en,
  input  logic [2:0]  force_code,
  output sync_st_e    nxt
);
  always_comb begin
    nxt = cur;
    if (force_en) begin
      nxt = decode_code(force_code);
    end else begin
      case (cur)
        ST_FREE: if (any_valid) nxt = ST_PRE;
        ST_PRE: begin
          if (lock_done)       nxt = ST_LOCK;
          else if (inact_done) nxt = ST_FREE;
        end
        ST_LOCK: begin
          if (!sel_active)      nxt = ST_HOLD;
          else if (!phase_lock) nxt = ST_LOL;
        end
        ST_LOL: begin
          if (!sel_active)     nxt = ST_HOLD;
          else if (phase_lock) nxt = ST_LOCK;
          else if (lol_done)   nxt = ST_HOLD;
        end
        ST_HOLD: if (any_valid) nxt = ST_PRE2;
        ST_PRE2: begin
          if (lock_done)       nxt = ST_LOCK;
          else if (inact_done) nxt = ST_HOLD;
        end
        default: nxt = ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/refsync_status.sv
module refsync_status (
  input  logic clk,
  input  logic rst_n,
  input  logic chg,
  input  logic clr,
  input  logic irq_en,
  output logic sticky,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sticky <= 1'b0;
    else if (chg) sticky <= 1'b1;
    else if (clr) sticky <= 1'b0;
  end

  assign irq = sticky & irq_en;
endmodule

// File: rtl/refsync_fsm.sv
module refsync_fsm
  import refsync_pkg::*;
#(
  parameter int NUM_REFS   = 4,
  parameter int QUAL_TICKS = 2,
  parameter int LOL_TICKS  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_valid,
  input  logic                sel_active,
  input  logic                phase_lock,
  input  logic                tick,
  input  logic                force_en,
  input  logic [2:0]          force_state,
  input  logic                irq_en,
  input  logic                stat_clr,
  output logic [2:0]          state_code,
  output logic                stat_chg,
  output logic                irq
);
  sync_st_e cur, nxt;
  logic [NUM_QUAL-1:0] q_en, q_done;
  logic qualifying;

  assign qualifying = (cur == ST_PRE) || (cur == ST_PRE2);

  always_comb begin
    q_en          = '0;
    q_en[Q_LOCK]  = qualifying && phase_lock;
    q_en[Q_INACT] = qualifying && !sel_active;
    q_en[Q_LOL]   = (cur == ST_LOL);
  end

  for (genvar g = 0; g < NUM_QUAL; g++) begin : g_qual
    localparam int LIM = (g == Q_LOL) ? LOL_TICKS : QUAL_TICKS;
    refsync_qual #(.LIMIT(LIM)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (q_en[g]),
      .tick (tick),
      .done (q_done[g])
    );
  end

  refsync_next u_next (
    .cur       (cur),
    .any_valid (|ref_valid),
    .sel_active(sel_active),
    .phase_lock(phase_lock),
    .lock_done (q_done[Q_LOCK]),
    .inact_done(q_done[Q_INACT]),
    .lol_done  (q_done[Q_LOL]),
    .force_en  (force_en),
    .force_code(force_state),
    .nxt       (nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_FREE;
    else        cur <= nxt;
  end

  refsync_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .chg   (nxt != cur),
    .clr   (stat_clr),
    .irq_en(irq_en),
    .sticky(stat_chg),
    .irq   (irq)
  );

  assign state_code = cur;
endmodule

// File: rtl/refsync_fsm_chk.sv
module refsync_fsm_chk #(
  parameter int NUM_REFS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_REFS-1:0] ref_valid,
  input logic                sel_active,
  input logic                phase_lock,
  input logic                force_en,
  input logic [2:0]          force_state,
  input logic                irq_en,
  input logic                stat_clr,
  input logic [2:0]          state_code,
  input logic                stat_chg,
  input logic                irq
);
  a_r1_reset_free: assert property (@(posedge clk)
    $rose(rst_n) |-> (state_code == 3'b000 && !stat_chg));

  a_r2_free_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b000 && |ref_valid && !force_en) |=> state_code == 3'b100);

  a_r5_force_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && force_state == 3'b010) |=> state_code == 3'b010);

  a_r6_sticky_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_code) |-> stat_chg);

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_chg && !stat_clr) |=> stat_chg);

  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_chg && irq_en));

  a_r8_locked_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'b010 && !force_en && sel_active && !phase_lock)
      |=> state_code == 3'b101);

  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    state_code <= 3'b101);
endmodule

bind refsync_fsm refsync_fsm_chk #(.NUM_REFS(NUM_REFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .sel_active(sel_active),
  .phase_lock(phase_lock), .force_en(force_en), .force_state(force_state),
  .irq_en(irq_en), .stat_clr(stat_clr), .state_code(state_code),
  .stat_chg(stat_chg), .irq(irq)
);

// File: tb/refsync_fsm_tb.sv
`timescale 1ns/1ps
module refsync_fsm_tb;
  localparam int NR = 4;
  localparam logic [2:0] FREE = 3'b000, HOLD = 3'b001, LOCK = 3'b010,
                         PRE2 = 3'b011, PRE = 3'b100, LOL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] ref_valid = '0;
  logic sel_active = 1'b1, phase_lock = 1'b0, tick = 1'b0;
  logic force_en = 1'b0, irq_en = 1'b0, stat_clr = 1'b0;
  logic [2:0] force_state = 3'b000;
  logic [2:0] state_code;
  logic stat_chg, irq;

  always #2.5 clk = ~clk;

  refsync_fsm #(.NUM_REFS(NR), .QUAL_TICKS(4), .LOL_TICKS(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .sel_active(sel_active),
    .phase_lock(phase_lock), .tick(tick), .force_en(force_en),
    .force_state(force_state), .irq_en(irq_en), .stat_clr(stat_clr),
    .state_code(state_code), .stat_chg(stat_chg), .irq(irq)
  );

  typedef struct {
    logic [2:0] st;
    logic       stk;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [2:0] prev_st = FREE;
  logic exp_stk = 1'b0;
  bit done = 0;

  task automatic check(input string tag, input logic [2:0] st, input logic stk,
                       input logic iq, input exp_t e);
    n_chk++;
    if (st !== e.st || stk !== e.stk || iq !== e.irq) begin
      n_fail++;
      $display("FAIL %s: state/sticky/irq got %b/%b/%b expected %b/%b/%b",
               tag, st, stk, iq, e.st, e.stk, e.irq);
    end
  endtask

  // driver: one clock, push the expected outputs after the edge
  task automatic cyc(input logic [2:0] st, input string tag);
    @(posedge clk); #1;
    if (st != prev_st) exp_stk = 1'b1;
    else if (stat_clr) exp_stk = 1'b0;
    prev_st = st;
    q.push_back('{st, exp_stk, exp_stk & irq_en, tag});
    @(negedge clk); #1;
  endtask

  task automatic ticks(input int n, input logic [2:0] st, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc(st, tag);
      tick = 1'b0;
    end
  endtask

  // monitor: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, state_code, stat_chg, irq, e);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r = '{FREE, 1'b0, 1'b0, "R1 reset"};
    check("R1 reset", state_code, stat_chg, irq, r);
    rst_n = 1'b1;
    #1;
    cyc(FREE, "R1 first cycle after reset");
    cyc(FREE, "R2 no valid ref stays free");
    ref_valid = 4'b0100;
    cyc(PRE, "R2 free to prelocked");
    irq_en = 1'b1;
    cyc(PRE, "R7 irq with enable");
    stat_clr = 1'b1;
    cyc(PRE, "R6 write-one clear");
    stat_clr = 1'b0;
    cyc(PRE, "R6 stays clear");
    // R3 qualification with a restart
    phase_lock = 1'b1;
    ticks(3, PRE, "R3 partial window");
    phase_lock = 1'b0;
    cyc(PRE, "R3 dropout");
    phase_lock = 1'b1;
    ticks(3, PRE, "R3 restarted window");
    ticks(1, PRE, "R3 final tick");
    cyc(LOCK, "R3 locked");
    // R8 / R9 loss of lock and quick return
    phase_lock = 1'b0;
    cyc(LOL, "R8 lock lost");
    phase_lock = 1'b1;
    cyc(LOCK, "R9 lock returns");
    ref_valid = '0;
    phase_lock = 1'b0;
    cyc(LOL, "R8 lock lost again");
    ticks(3, LOL, "R9 window");
    cyc(HOLD, "R9 timeout to holdover");
    // R10 holdover and prelocked 2
    cyc(HOLD, "R10 no ref stays holdover");
    ref_valid = 4'b0001;
    cyc(PRE2, "R10 holdover to prelocked 2");
    sel_active = 1'b0;
    ticks(4, PRE2, "R10 inactivity window");
    ref_valid = '0;
    cyc(HOLD, "R10 inactivity to holdover");
    cyc(HOLD, "R10 holdover idle");
    ref_valid = 4'b0010;
    cyc(PRE2, "R10 prelocked 2 again");
    sel_active = 1'b1;
    phase_lock = 1'b1;
    ticks(4, PRE2, "R10 lock window");
    cyc(LOCK, "R10 prelocked 2 to locked");
    ref_valid = '0;
    sel_active = 1'b0;
    cyc(HOLD, "R8 reference gone while locked");
    // R5 force, then R4 inactivity from prelocked
    force_en = 1'b1;
    force_state = 3'b100;
    cyc(PRE, "R5 force prelocked");
    cyc(PRE, "R5 force held");
    force_en = 1'b0;
    phase_lock = 1'b0;
    ticks(4, PRE, "R4 inactivity window");
    cyc(FREE, "R4 prelocked to free-run");
    force_en = 1'b1;
    force_state = 3'b010;
    cyc(LOCK, "R5 force locked");
    cyc(LOCK, "R5 force overrides lock loss");
    force_state = 3'b111;
    cyc(FREE, "R11 unused code is free-run");
    force_state = 3'b101;
    stat_clr = 1'b1;
    cyc(LOL, "R6 set wins over clear");
    stat_clr = 1'b0;
    force_en = 1'b0;
    sel_active = 1'b1;
    phase_lock = 1'b1;
    cyc(LOCK, "R9 loss-of-lock to locked");
    irq_en = 1'b0;
    cyc(LOCK, "R7 irq masked");
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule